// File: doc/BRIEF.md
# Nibble Bus Register Interface

This block sits between a microprocessor with a 4-bit multiplexed-style bus and a real-time clock core made of thirteen time-digit counters and three control registers. The processor reaches sixteen 4-bit locations through a 4-bit address, a 4-bit data bus, an address strobe, active-low read and write strobes, an active-low select and an active-high power-good select. Locations 0 to 12 are the time digits, which live outside the block and are reached only through ports. Locations 13, 14 and 15 are the three control registers, which are held inside the block.

The block latches the address, recognises write strobes, gates the read-data enable, hides digit bits that do not exist, and enforces the special write rules of the control registers: a sticky interrupt flag that software can only clear, a hold bit and a divider-reset bit that drop when power-good falls, and an hour-format bit that changes only while the divider reset is set. It also produces the busy status that software polls before touching the digits under hold. The tri-state data driver stays outside; the block gives the data and a separate output enable.

All inputs are taken as already synchronous to `clk`. Reset is synchronous and active low.

Top module: `nbus_regif`

## Requirements
- R1: The address latch passes `addr_in` through while `addr_strobe` is 1 and `bus_en_n` is 0, and keeps its last captured value when `addr_strobe` is 0; with `addr_strobe` held at 1 the address follows `addr_in` directly.
- R2: A write happens only in the cycle where `wr_n` is seen rising (0 in the previous cycle, 1 now) while `pwr_ok` is 1 and `bus_en_n` is 0. A write to location 0..12 gives a one-cycle pulse on bit `addr` of `digit_wr_en` one cycle later, with the data on `digit_wr_data`.
- R3: `data_oe` is 1 exactly when `pwr_ok` is 1, `bus_en_n` is 0, `rd_n` is 0 and `wr_n` is 1; with both strobes low no read is driven.
- R4: Bits that do not exist are dropped on write and read as 0: bit 3 at locations 1, 3, 5 and 12; bits 3..2 at location 7; bits 3..1 at location 9.
- R5: A read of locations 0..12 returns digit `n` from `time_in[4n+3:4n]`, masked as in R4.
- R6: Location 13 reads as {adjust, irq, busy, hold} from bit 3 to bit 0; writing bit 1 has no effect.
- R7: The irq bit is set by a pulse on `irq_set`, is cleared only by a write of 0 to bit 2 of location 13, and a write of 1 leaves it unchanged; a set in the same cycle as a clear wins.
- R8: Location 14 stores {rate[1:0], interrupt mode, mask} from bit 3 to bit 0 and drives `rate_sel`, `int_mode` and `pulse_mask`.
- R9: Location 15 stores {test, 24-hour, stop, divider reset} from bit 3 to bit 0; the 24-hour bit (1 = 24-hour) takes the written value only when the divider reset bit was already 1 before the write.
- R10: When `pwr_ok` is 0, hold and divider reset are both 0 from the next cycle on, and writes are ignored.
- R11: The adjust bit is set by writing 1 to bit 3 of location 13 and returns to 0 on a pulse of `adj_done`.
- R12: Busy reads 1 out of reset, is 1 one cycle after `update_pending` is 1, and is 0 one cycle after hold is 1 with no update pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | 4 | Register address from the processor |
| addr_strobe | input | 1 | Address latch open while 1 |
| bus_en_n | input | 1 | Active-low bus select |
| pwr_ok | input | 1 | Active-high select, also power-good |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, write on its rising edge |
| data_in | input | 4 | Write data |
| data_out | output | 4 | Read data |
| data_oe | output | 1 | Output enable for the external data driver |
| time_in | input | 52 | Current time digits, digit n in bits 4n+3..4n |
| digit_wr_en | output | 13 | One-hot write pulse to the digit counters |
| digit_wr_data | output | 4 | Masked data for the digit write |
| irq_set | input | 1 | Pulse from the interrupt logic setting the irq bit |
| adj_done | input | 1 | Pulse ending a 30-second adjustment |
| update_pending | input | 1 | Carry update of the digits pending or running |
| irq_flag | output | 1 | Current irq bit |
| hold | output | 1 | Hold request to the counters |
| adj_req | output | 1 | 30-second adjustment request |
| rate_sel | output | 2 | Pulse rate selection |
| int_mode | output | 1 | 1 = interrupt mode, 0 = fixed pulse mode |
| pulse_mask | output | 1 | Pulse output mask |
| test_mode | output | 1 | Test mode request |
| mode24 | output | 1 | 1 = 24-hour format |
| stop | output | 1 | Stop request to the divider |
| div_reset | output | 1 | Sub-second divider reset |

## Verification
The latch is driven both with the strobe held high and with it pulsed, then with the address changed while closed, which separates a transparent latch from a plain register or a missing one. Writes are tried with good selects, with the active-low select off and with power-good low, telling a real edge detector from a level decode. The control registers are hit with patterns that set and clear each special bit against its rule (irq written 1 and 0 while set, the hour bit written with the divider reset off and on, the busy bit written), so that a plain read/write register fails where a rule is missing. Digit reads use all-ones data at every width of location, which shows any unmasked bit.

// File: rtl/nbus_pkg.sv
// Shared constants and helpers for the nibble bus register interface.
// Assumes a 4-bit register map: 13 digit locations, then three control registers.
package nbus_pkg;
    localparam int NIB_W      = 4;
    localparam int LOC_W      = 4;
    localparam int DIGITS     = 13;
    localparam logic [LOC_W-1:0] LOC_CTRL_D = 4'd13;
    localparam logic [LOC_W-1:0] LOC_CTRL_E = 4'd14;
    localparam logic [LOC_W-1:0] LOC_CTRL_F = 4'd15;

    // Bits that exist at each digit location.
    function automatic logic [NIB_W-1:0] loc_mask(input logic [LOC_W-1:0] loc);
        case (loc)
            4'd1, 4'd3, 4'd5, 4'd12: loc_mask = 4'b0111;
            4'd7:                    loc_mask = 4'b0011;
            4'd9:                    loc_mask = 4'b0001;
            default:                 loc_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/nbus_addr_latch.sv
// Address latch: transparent while the strobe is high and the bus is selected,
// keeps the last captured address otherwise. Inputs are synchronous to clk.
module nbus_addr_latch #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_strobe,
    input  logic              bus_en_n,
    output logic [ADDR_W-1:0] addr_eff
);
    logic              open_w;
    logic [ADDR_W-1:0] addr_q;

    assign open_w = addr_strobe && !bus_en_n;

    // Capture the address while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (open_w) addr_q <= addr_in;
    end

    // Pass through while open, held value while closed.
    assign addr_eff = open_w ? addr_in : addr_q;

    assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !open_w |=> $stable(addr_q));
endmodule

// File: rtl/nbus_strobe.sv
// Strobe decode: finds the rising edge of the write strobe and gates the read enable.
// Assumes rd_n, wr_n and the selects are already synchronous to clk.
module nbus_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en_n,
    input  logic pwr_ok,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_fire,
    output logic rd_oe
);
    logic wr_n_q;
    logic sel_w;

    assign sel_w = pwr_ok && !bus_en_n;

    // Previous write strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= wr_n;
    end

    // Write on the low-to-high transition; read blocked while write is low.
    assign wr_fire = sel_w && wr_n && !wr_n_q;
    assign rd_oe   = sel_w && !rd_n && wr_n;

    assert_fire_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> ($past(wr_n) == 1'b0));
    assert_no_read_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !rd_oe);
endmodule

// File: rtl/nbus_ctrl_regs.sv
// Control registers at locations 13..15 with their write rules, plus the busy status.
// Assumes irq_set and adj_done are single-cycle pulses from the clock core.
module nbus_ctrl_regs
    import nbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [LOC_W-1:0] waddr,
    input  logic [NIB_W-1:0] wdata,
    input  logic             pwr_ok,
    input  logic             irq_set,
    input  logic             adj_done,
    input  logic             update_pending,
    output logic [NIB_W-1:0] reg_d,
    output logic [NIB_W-1:0] reg_e,
    output logic [NIB_W-1:0] reg_f
);
    logic wr_d, wr_e, wr_f;
    logic adj_q, irq_q, busy_q, hold_q;
    logic test_q, mode24_q, stop_q, rst_bit_q;
    logic [NIB_W-1:0] e_q;

    assign wr_d = wr_fire && (waddr == LOC_CTRL_D);
    assign wr_e = wr_fire && (waddr == LOC_CTRL_E);
    assign wr_f = wr_fire && (waddr == LOC_CTRL_F);

    // Register D: adjust, sticky irq, hold; hold drops without power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q  <= 1'b0;
            irq_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (wr_d)          adj_q <= wdata[3];
            else if (adj_done) adj_q <= 1'b0;
            if (irq_set)                 irq_q <= 1'b1;
            else if (wr_d && !wdata[2])  irq_q <= 1'b0;
            if (!pwr_ok)       hold_q <= 1'b0;
            else if (wr_d)     hold_q <= wdata[0];
        end
    end

    // Busy: set while not held or while an update is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b1;
        else        busy_q <= !hold_q || update_pending;
    end

    // Register E: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)    e_q <= '0;
        else if (wr_e) e_q <= wdata;
    end

    // Register F: hour format guarded by the divider reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q    <= 1'b0;
            mode24_q  <= 1'b0;
            stop_q    <= 1'b0;
            rst_bit_q <= 1'b0;
        end else begin
            if (wr_f) begin
                test_q <= wdata[3];
                stop_q <= wdata[1];
                if (rst_bit_q) mode24_q <= wdata[2];
            end
            if (!pwr_ok)   rst_bit_q <= 1'b0;
            else if (wr_f) rst_bit_q <= wdata[0];
        end
    end

    assign reg_d = {adj_q, irq_q, busy_q, hold_q};
    assign reg_e = e_q;
    assign reg_f = {test_q, mode24_q, stop_q, rst_bit_q};

    assert_irq_only_hw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && !irq_set) |=> !irq_q);
    assert_pwr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!hold_q && !rst_bit_q));
    assert_hour_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_bit_q |=> $stable(mode24_q));
    assert_busy_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        update_pending |=> busy_q);
endmodule

// File: rtl/nbus_read_mux.sv
// Read data selection: digits from the core, masked per location, or control registers.
// Assumes time_in is packed digit 0 in the low nibble.
module nbus_read_mux
    import nbus_pkg::*;
#(
    parameter int NUM_DIGITS = 13
) (
    input  logic [LOC_W-1:0]            raddr,
    input  logic [NUM_DIGITS*NIB_W-1:0] time_in,
    input  logic [NIB_W-1:0]            reg_d,
    input  logic [NIB_W-1:0]            reg_e,
    input  logic [NIB_W-1:0]            reg_f,
    output logic [NIB_W-1:0]            rdata
);
    logic [NIB_W-1:0] digit_arr [NUM_DIGITS];

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_unpack
        assign digit_arr[i] = time_in[i*NIB_W +: NIB_W];
    end

    // Select the addressed location.
    always_comb begin
        if (raddr == LOC_CTRL_D)          rdata = reg_d;
        else if (raddr == LOC_CTRL_E)     rdata = reg_e;
        else if (raddr == LOC_CTRL_F)     rdata = reg_f;
        else if (int'(raddr) < NUM_DIGITS) rdata = digit_arr[raddr] & loc_mask(raddr);
        else                               rdata = '0;
    end
endmodule

// File: rtl/nbus_regif.sv
// Top: nibble bus register interface of the real-time clock.
// Latches the address, decodes strobes, writes digits through ports and holds control registers.
module nbus_regif
    import nbus_pkg::*;
#(
    parameter int NUM_DIGITS = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LOC_W-1:0]            addr_in,
    input  logic                        addr_strobe,
    input  logic                        bus_en_n,
    input  logic                        pwr_ok,
    input  logic                        rd_n,
    input  logic                        wr_n,
    input  logic [NIB_W-1:0]            data_in,
    output logic [NIB_W-1:0]            data_out,
    output logic                        data_oe,
    input  logic [NUM_DIGITS*NIB_W-1:0] time_in,
    output logic [NUM_DIGITS-1:0]       digit_wr_en,
    output logic [NIB_W-1:0]            digit_wr_data,
    input  logic                        irq_set,
    input  logic                        adj_done,
    input  logic                        update_pending,
    output logic                        irq_flag,
    output logic                        hold,
    output logic                        adj_req,
    output logic [1:0]                  rate_sel,
    output logic                        int_mode,
    output logic                        pulse_mask,
    output logic                        test_mode,
    output logic                        mode24,
    output logic                        stop,
    output logic                        div_reset
);
    logic [LOC_W-1:0] addr_eff;
    logic             wr_fire;
    logic [NIB_W-1:0] reg_d, reg_e, reg_f;
    logic [NUM_DIGITS-1:0] hit;
    logic [NUM_DIGITS-1:0] wen_q;
    logic [NIB_W-1:0]      wdat_q;

    nbus_addr_latch #(.ADDR_W(LOC_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_strobe(addr_strobe),
        .bus_en_n(bus_en_n), .addr_eff(addr_eff));

    nbus_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .pwr_ok(pwr_ok),
        .rd_n(rd_n), .wr_n(wr_n), .wr_fire(wr_fire), .rd_oe(data_oe));

    nbus_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .waddr(addr_eff), .wdata(data_in),
        .pwr_ok(pwr_ok), .irq_set(irq_set), .adj_done(adj_done),
        .update_pending(update_pending), .reg_d(reg_d), .reg_e(reg_e), .reg_f(reg_f));

    nbus_read_mux #(.NUM_DIGITS(NUM_DIGITS)) u_rmux (
        .raddr(addr_eff), .time_in(time_in), .reg_d(reg_d), .reg_e(reg_e),
        .reg_f(reg_f), .rdata(data_out));

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_hit
        assign hit[i] = wr_fire && (addr_eff == LOC_W'(i));
    end

    // Register the one-hot digit write pulse and its masked data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q  <= '0;
            wdat_q <= '0;
        end else begin
            wen_q <= hit;
            if (wr_fire) wdat_q <= data_in & loc_mask(addr_eff);
        end
    end

    assign digit_wr_en   = wen_q;
    assign digit_wr_data = wdat_q;
    assign adj_req    = reg_d[3];
    assign irq_flag   = reg_d[2];
    assign hold       = reg_d[0];
    assign rate_sel   = reg_e[3:2];
    assign int_mode   = reg_e[1];
    assign pulse_mask = reg_e[0];
    assign test_mode  = reg_f[3];
    assign mode24     = reg_f[2];
    assign stop       = reg_f[1];
    assign div_reset  = reg_f[0];

    assert_digit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_wr_en));
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_wr_en != '0) |=> (digit_wr_en == '0));
endmodule

// File: tb/nbus_regif_tb.sv
module nbus_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr_in = '0;
    logic        addr_strobe = 1'b1;
    logic        bus_en_n = 1'b1;
    logic        pwr_ok = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  data_in = '0;
    logic [3:0]  data_out;
    logic        data_oe;
    logic [51:0] time_in = '0;
    logic [12:0] digit_wr_en;
    logic [3:0]  digit_wr_data;
    logic        irq_set = 1'b0, adj_done = 1'b0, update_pending = 1'b0;
    logic        irq_flag, hold, adj_req, int_mode, pulse_mask;
    logic        test_mode, mode24, stop, div_reset;
    logic [1:0]  rate_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    nbus_regif u_dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_digit(input int n, input logic [3:0] v);
        time_in[n*4 +: 4] = v;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr_in = a; addr_strobe = 1'b1; bus_en_n = 1'b0; data_in = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        addr_in = a; addr_strobe = 1'b1; bus_en_n = 1'b0; rd_n = 1'b0;
        #1 d = data_out;
        rd_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        do_read(4'd13, v); chk("R12 reset busy set", v, 4'b0010);
        do_read(4'd14, v); chk("R8 reset E", v, 4'b0000);
        do_read(4'd15, v); chk("R9 reset F", v, 4'b0000);
    endtask

    task automatic t_latch();
        set_digit(5, 4'h6); set_digit(9, 4'h1);
        @(negedge clk);
        addr_in = 4'd5; addr_strobe = 1'b1; bus_en_n = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b0; addr_in = 4'd9; rd_n = 1'b0;
        #1 chk("R1 latched addr held", data_out, 4'h6);
        addr_strobe = 1'b1;
        #1 chk("R1 transparent", data_out, 4'h1);
        rd_n = 1'b1;
    endtask

    task automatic t_write();
        do_write(4'd4, 4'h9);
        chk("R2 digit pulse", digit_wr_en, 13'h0010);
        chk("R2 digit data", digit_wr_data, 4'h9);
        @(negedge clk);
        chk("R2 pulse one cycle", digit_wr_en, 13'h0);
        // Select off: no write
        @(negedge clk); addr_in = 4'd2; bus_en_n = 1'b1; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); chk("R2 no write when deselected", digit_wr_en, 13'h0);
        bus_en_n = 1'b0;
        // Level low without a rising edge: no write
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 no write on level", digit_wr_en, 13'h0);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_read_gate();
        @(negedge clk);
        addr_in = 4'd0; bus_en_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        #1 chk("R3 read enable", data_oe, 1'b1);
        wr_n = 1'b0;
        #1 chk("R3 both low blocks read", data_oe, 1'b0);
        rd_n = 1'b1;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); rd_n = 1'b0; bus_en_n = 1'b1;
        #1 chk("R3 deselected", data_oe, 1'b0);
        bus_en_n = 1'b0; pwr_ok = 1'b0;
        #1 chk("R3 power-good low", data_oe, 1'b0);
        pwr_ok = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_mask();
        logic [3:0] v;
        for (int i = 0; i < 13; i++) set_digit(i, 4'hF);
        do_read(4'd1, v);  chk("R4 loc1 read", v, 4'b0111);
        do_read(4'd7, v);  chk("R4 loc7 read", v, 4'b0011);
        do_read(4'd9, v);  chk("R4 loc9 read", v, 4'b0001);
        do_read(4'd12, v); chk("R4 loc12 read", v, 4'b0111);
        set_digit(10, 4'hA);
        do_read(4'd10, v); chk("R5 full digit read", v, 4'hA);
        do_write(4'd7, 4'hF);
        chk("R4 loc7 write masked", digit_wr_data, 4'h3);
        do_write(4'd9, 4'hF);
        chk("R4 loc9 write masked", digit_wr_data, 4'h1);
    endtask

    task automatic t_irq();
        logic [3:0] v;
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        chk("R7 irq set by pulse", irq_flag, 1'b1);
        do_write(4'd13, 4'b0100);
        do_read(4'd13, v); chk("R7 write 1 keeps irq", v[2], 1'b1);
        do_write(4'd13, 4'b0000);
        do_read(4'd13, v); chk("R7 write 0 clears irq", v[2], 1'b0);
        // Set and clear together: set wins
        @(negedge clk);
        addr_in = 4'd13; data_in = 4'b0000; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        chk("R7 set beats clear", irq_flag, 1'b1);
        do_write(4'd13, 4'b0000);
    endtask

    task automatic t_busy();
        logic [3:0] v;
        do_write(4'd13, 4'b0111);
        @(negedge clk);
        do_read(4'd13, v); chk("R6 busy not writable, held", v, 4'b0001);
        chk("R6 hold out", hold, 1'b1);
        update_pending = 1'b1;
        @(negedge clk);
        do_read(4'd13, v); chk("R12 busy on pending", v, 4'b0011);
        update_pending = 1'b0;
        @(negedge clk);
        do_read(4'd13, v); chk("R12 busy clears", v, 4'b0001);
    endtask

    task automatic t_adj();
        logic [3:0] v;
        do_write(4'd13, 4'b1100);
        chk("R11 adjust set", adj_req, 1'b1);
        @(negedge clk); adj_done = 1'b1;
        @(negedge clk); adj_done = 1'b0;
        do_read(4'd13, v); chk("R11 adjust cleared", v[3], 1'b0);
    endtask

    task automatic t_rege();
        logic [3:0] v;
        do_write(4'd14, 4'b1110);
        do_read(4'd14, v); chk("R8 E readback", v, 4'b1110);
        chk("R8 E outputs", {rate_sel, int_mode, pulse_mask}, 4'b1110);
    endtask

    task automatic t_regf();
        logic [3:0] v;
        do_write(4'd15, 4'b0100);
        do_read(4'd15, v); chk("R9 hour bit locked", v, 4'b0000);
        do_write(4'd15, 4'b0001);
        do_write(4'd15, 4'b0100);
        do_read(4'd15, v); chk("R9 hour bit written under reset", v, 4'b0100);
        do_write(4'd15, 4'b1010);
        do_read(4'd15, v); chk("R9 hour kept, test/stop", v, 4'b1110);
        chk("R9 outputs", {test_mode, mode24, stop, div_reset}, 4'b1110);
    endtask

    task automatic t_pwr();
        do_write(4'd15, 4'b0001);
        do_write(4'd13, 4'b0101);
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk);
        chk("R10 hold cleared", hold, 1'b0);
        chk("R10 reset cleared", div_reset, 1'b0);
        @(negedge clk); addr_in = 4'd3; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); chk("R10 write ignored", digit_wr_en, 13'h0);
        pwr_ok = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_write();
        t_read_gate();
        t_mask();
        t_irq();
        t_busy();
        t_adj();
        t_rege();
        t_regf();
        t_pwr();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule